// File: doc/BRIEF.md
# Concurrent Three-Port SPI Converter Front End

This block services two serial analog-to-digital converters and one serial digital-to-analog converter at the same time. Each converter has its own SPI port with its own serial clock, chip select and data line, so no transfer waits for another. All three ports run in lockstep from one shared frame timer. With the default settings and a 57.6 MHz system clock, the serial clock is 3.2 MHz (18 system clocks per period). A 16-bit frame then fills the whole 288-cycle sample period, which gives a 200 kHz sample rate.

In every frame the block shifts in one 16-bit word from each ADC and keeps its low 12 bits as the sample. It shifts out one 16-bit word to the DAC, made of four zero bits followed by the 12-bit value on the parallel DAC input. The serial clock is made by ordinary logic and leaves through a plain output. Received samples appear on parallel outputs together with a one-cycle ready strobe.

Cycle numbers below count from t = 0, the cycle in which chip select is high. A frame spans t = 0 to 287.

Top module: `spi_conv_frontend`

## Requirements
- R1: On all three ports, serial clock and chip select are identical in every cycle.
- R2: Chip select (active low) is high for exactly one cycle at t = 0 of each 288-cycle frame and low for the rest of the frame. The serial clock is low while chip select is high.
- R3: The serial clock has a period of 18 cycles: low for t mod 18 in 0..8 and high for t mod 18 in 9..17. This gives 16 periods per frame.
- R4: The ready strobe is high only in cycle t = 284 of each frame. Both ADC sample outputs take their new values in that same cycle and hold them until the next strobe.
- R5: Each ADC word is received MSB first. Bit b (b = 0 is bit 15) is sampled on the clock edge that ends cycle t = 18b+13. The sample output is bits 11..0 of the word, and bits 15..12 have no effect on it.
- R6: The DAC data line carries {4'b0000, value} MSB first. Bit b is driven from t = 18b through t = 18b+17, so it changes only when the serial clock is low.
- R7: The DAC input is captured only on the edge that ends the cycle before chip select goes high (t = 287 of the previous frame). Values present in any other cycle do not appear in that frame's word.
- R8: During reset, chip selects are high, serial clocks low, the DAC data line low, the strobe low and both samples zero. The first frame's t = 0 is the first cycle after the first clock edge with reset low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| dac_in | input | 12 | Parallel value to send to the DAC |
| adc0_miso | input | 1 | Serial data from ADC 0 |
| adc1_miso | input | 1 | Serial data from ADC 1 |
| adc0_sclk | output | 1 | Serial clock to ADC 0 |
| adc0_cs_n | output | 1 | Chip select to ADC 0, active low |
| adc1_sclk | output | 1 | Serial clock to ADC 1 |
| adc1_cs_n | output | 1 | Chip select to ADC 1, active low |
| dac_sclk | output | 1 | Serial clock to the DAC |
| dac_cs_n | output | 1 | Chip select to the DAC, active low |
| dac_mosi | output | 1 | Serial data to the DAC |
| adc0_data | output | 12 | Latest sample from ADC 0 |
| adc1_data | output | 12 | Latest sample from ADC 1 |
| adc_valid | output | 1 | One-cycle strobe marking new samples |

## Verification
Two events can share the frame-boundary edge: capture of the DAC input and the start of the next frame's chip-select pulse and MOSI reload. The bench changes the DAC input exactly in cycle t = 287, which must be captured. It also changes it at t = 0 and in mid-frame, and those changes must not be captured. It then judges the whole MOSI bit stream of the following frame against the captured value. Samples that return on the same frame edge are checked as well: the ready strobe must land on its cycle and the previous samples must still hold in mid-frame.

// File: rtl/spi_conv_pkg.sv
package spi_conv_pkg;
    localparam int CLK_DIV    = 18;
    localparam int FRAME_BITS = 16;
    localparam int DATA_BITS  = 12;
    localparam int NUM_ADC    = 2;

    localparam int HALF_DIV   = CLK_DIV / 2;
    localparam int SAMPLE_PH  = HALF_DIV + HALF_DIV / 2 + 1;
    localparam int PH_W       = $clog2(CLK_DIV);
    localparam int BIT_W      = $clog2(FRAME_BITS);
    localparam int PAD_BITS   = FRAME_BITS - DATA_BITS;

    typedef struct packed {
        logic frame_start;
        logic sclk_lvl;
        logic shift_now;
        logic sample_now;
        logic last_sample;
    } frame_tick_t;

    function automatic logic [FRAME_BITS-1:0] pad_dac(input logic [DATA_BITS-1:0] v);
        return {{PAD_BITS{1'b0}}, v};
    endfunction
endpackage

// File: rtl/spi_frame_timer.sv
module spi_frame_timer
    import spi_conv_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    output frame_tick_t tick
);
    logic [PH_W-1:0]  phase;
    logic [BIT_W-1:0] bitn;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= '0;
            bitn  <= '0;
        end else if (phase == PH_W'(CLK_DIV - 1)) begin
            phase <= '0;
            bitn  <= (bitn == BIT_W'(FRAME_BITS - 1)) ? '0 : bitn + 1'b1;
        end else begin
            phase <= phase + 1'b1;
        end
    end

    always_comb begin
        tick.frame_start = (phase == '0) && (bitn == '0);
        tick.sclk_lvl    = (phase >= PH_W'(HALF_DIV));
        tick.shift_now   = (phase == '0);
        tick.sample_now  = (phase == PH_W'(SAMPLE_PH));
        tick.last_sample = tick.sample_now && (bitn == BIT_W'(FRAME_BITS - 1));
    end
endmodule

// File: rtl/spi_rx_lane.sv
module spi_rx_lane
    import spi_conv_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 frame_start,
    input  logic                 sclk_lvl,
    input  logic                 sample_now,
    input  logic                 last_sample,
    input  logic                 miso,
    output logic                 sclk,
    output logic                 cs_n,
    output logic [DATA_BITS-1:0] data
);
    logic [DATA_BITS-2:0] shr;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk <= 1'b0;
            cs_n <= 1'b1;
            shr  <= '0;
            data <= '0;
        end else begin
            sclk <= sclk_lvl;
            cs_n <= frame_start;
            if (sample_now) shr <= {shr[DATA_BITS-3:0], miso};
            if (last_sample) data <= {shr, miso};
        end
    end
endmodule

// File: rtl/spi_tx_lane.sv
module spi_tx_lane
    import spi_conv_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 frame_start,
    input  logic                 sclk_lvl,
    input  logic                 shift_now,
    input  logic [DATA_BITS-1:0] value,
    output logic                 sclk,
    output logic                 cs_n,
    output logic                 mosi
);
    logic [FRAME_BITS-1:0] shr;
    logic [FRAME_BITS-1:0] word;

    always_comb word = pad_dac(value);

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk <= 1'b0;
            cs_n <= 1'b1;
            mosi <= 1'b0;
            shr  <= '0;
        end else begin
            sclk <= sclk_lvl;
            cs_n <= frame_start;
            if (frame_start) begin
                mosi <= word[FRAME_BITS-1];
                shr  <= {word[FRAME_BITS-2:0], 1'b0};
            end else if (shift_now) begin
                mosi <= shr[FRAME_BITS-1];
                shr  <= {shr[FRAME_BITS-2:0], 1'b0};
            end
        end
    end
endmodule

// File: rtl/spi_conv_frontend.sv
module spi_conv_frontend
    import spi_conv_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [DATA_BITS-1:0] dac_in,
    input  logic                 adc0_miso,
    input  logic                 adc1_miso,
    output logic                 adc0_sclk,
    output logic                 adc0_cs_n,
    output logic                 adc1_sclk,
    output logic                 adc1_cs_n,
    output logic                 dac_sclk,
    output logic                 dac_cs_n,
    output logic                 dac_mosi,
    output logic [DATA_BITS-1:0] adc0_data,
    output logic [DATA_BITS-1:0] adc1_data,
    output logic                 adc_valid
);
    frame_tick_t tick;

    logic [NUM_ADC-1:0]                miso_v;
    logic [NUM_ADC-1:0]                sclk_v;
    logic [NUM_ADC-1:0]                cs_v;
    logic [NUM_ADC-1:0][DATA_BITS-1:0] data_v;

    spi_frame_timer u_timer (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    assign miso_v = {adc1_miso, adc0_miso};

    for (genvar i = 0; i < NUM_ADC; i++) begin : g_adc
        spi_rx_lane u_rx (
            .clk         (clk),
            .rst         (rst),
            .frame_start (tick.frame_start),
            .sclk_lvl    (tick.sclk_lvl),
            .sample_now  (tick.sample_now),
            .last_sample (tick.last_sample),
            .miso        (miso_v[i]),
            .sclk        (sclk_v[i]),
            .cs_n        (cs_v[i]),
            .data        (data_v[i])
        );
    end

    spi_tx_lane u_tx (
        .clk         (clk),
        .rst         (rst),
        .frame_start (tick.frame_start),
        .sclk_lvl    (tick.sclk_lvl),
        .shift_now   (tick.shift_now),
        .value       (dac_in),
        .sclk        (dac_sclk),
        .cs_n        (dac_cs_n),
        .mosi        (dac_mosi)
    );

    always_ff @(posedge clk) begin
        if (rst) adc_valid <= 1'b0;
        else     adc_valid <= tick.last_sample;
    end

    assign adc0_sclk = sclk_v[0];
    assign adc1_sclk = sclk_v[1];
    assign adc0_cs_n = cs_v[0];
    assign adc1_cs_n = cs_v[1];
    assign adc0_data = data_v[0];
    assign adc1_data = data_v[1];
endmodule

// File: rtl/spi_conv_frontend_chk.sv
module spi_conv_frontend_chk
    import spi_conv_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic                 adc0_sclk,
    input logic                 adc0_cs_n,
    input logic                 adc1_sclk,
    input logic                 adc1_cs_n,
    input logic                 dac_sclk,
    input logic                 dac_cs_n,
    input logic                 dac_mosi,
    input logic [DATA_BITS-1:0] adc0_data,
    input logic [DATA_BITS-1:0] adc1_data,
    input logic                 adc_valid
);
    // R1: the three ports stay in lockstep
    a_r1_lanes_locked: assert property (@(posedge clk) disable iff (rst)
        (adc0_sclk == dac_sclk) && (adc1_sclk == dac_sclk) &&
        (adc0_cs_n == dac_cs_n) && (adc1_cs_n == dac_cs_n));

    // R2: no clock activity while deselected
    a_r2_idle_clock_low: assert property (@(posedge clk) disable iff (rst)
        dac_cs_n |-> !dac_sclk);

    // R3: a high phase lasts longer than one cycle
    a_r3_high_min: assert property (@(posedge clk) disable iff (rst)
        $rose(dac_sclk) |=> dac_sclk);

    // R4: strobe is a single-cycle pulse inside the transfer
    a_r4_valid_single: assert property (@(posedge clk) disable iff (rst)
        adc_valid |=> !adc_valid);

    a_r4_valid_in_frame: assert property (@(posedge clk) disable iff (rst)
        adc_valid |-> !dac_cs_n);

    // R4: samples move only together with the strobe
    a_r4_data_hold: assert property (@(posedge clk) disable iff (rst)
        !adc_valid |-> ($stable(adc0_data) && $stable(adc1_data)));

    // R6: DAC data is steady through a high clock phase
    a_r6_mosi_steady: assert property (@(posedge clk) disable iff (rst)
        (dac_sclk && $past(dac_sclk)) |-> $stable(dac_mosi));
endmodule

bind spi_conv_frontend spi_conv_frontend_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .adc0_sclk (adc0_sclk),
    .adc0_cs_n (adc0_cs_n),
    .adc1_sclk (adc1_sclk),
    .adc1_cs_n (adc1_cs_n),
    .dac_sclk  (dac_sclk),
    .dac_cs_n  (dac_cs_n),
    .dac_mosi  (dac_mosi),
    .adc0_data (adc0_data),
    .adc1_data (adc1_data),
    .adc_valid (adc_valid)
);

// File: tb/spi_conv_frontend_bench.sv
module spi_conv_frontend_bench;
    localparam int FRAME = 288;
    localparam int NF    = 12;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] dac_in = '0;
    logic        adc0_miso = 1'b0;
    logic        adc1_miso = 1'b0;
    logic        adc0_sclk, adc0_cs_n, adc1_sclk, adc1_cs_n;
    logic        dac_sclk, dac_cs_n, dac_mosi, adc_valid;
    logic [11:0] adc0_data, adc1_data;

    int tests = 0;
    int fails = 0;
    bit done  = 0;

    always #4 clk = ~clk;

    spi_conv_frontend u_spi_conv_frontend (
        .clk(clk), .rst(rst), .dac_in(dac_in),
        .adc0_miso(adc0_miso), .adc1_miso(adc1_miso),
        .adc0_sclk(adc0_sclk), .adc0_cs_n(adc0_cs_n),
        .adc1_sclk(adc1_sclk), .adc1_cs_n(adc1_cs_n),
        .dac_sclk(dac_sclk), .dac_cs_n(dac_cs_n), .dac_mosi(dac_mosi),
        .adc0_data(adc0_data), .adc1_data(adc1_data), .adc_valid(adc_valid)
    );

    task automatic chk(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic exp_sclk(input int t);
        return (t % 18) >= 9;
    endfunction

    function automatic logic word_bit(input logic [15:0] w, input int t);
        return w[15 - t / 18];
    endfunction

    initial begin
        logic [15:0] w0, w1;
        logic [11:0] dac_cur, dac_nxt, prev0, prev1;
        void'($urandom(32'd4242));

        dac_in = 12'hFFF;
        dac_cur = 12'hFFF;
        repeat (4) @(posedge clk);
        @(negedge clk);
        // R8: reset state
        chk("R8 cs_n", adc0_cs_n & adc1_cs_n & dac_cs_n, 1);
        chk("R8 sclk", adc0_sclk | adc1_sclk | dac_sclk, 0);
        chk("R8 mosi", dac_mosi, 0);
        chk("R8 valid", adc_valid, 0);
        chk("R8 data0", adc0_data, 0);
        chk("R8 data1", adc1_data, 0);
        rst = 1'b0;
        @(posedge clk);
        prev0 = '0;
        prev1 = '0;

        for (int f = 0; f < NF; f++) begin
            case (f)
                0: begin w0 = 16'hFFFF; w1 = 16'h0000; dac_nxt = 12'h000; end
                1: begin w0 = 16'hF000; w1 = 16'h0FFF; dac_nxt = 12'hA5A; end
                2: begin w0 = 16'hA5A5; w1 = 16'h5A5A; dac_nxt = 12'h801; end
                default: begin
                    w0 = 16'($urandom); w1 = 16'($urandom); dac_nxt = 12'($urandom);
                end
            endcase
            for (int t = 0; t < FRAME; t++) begin
                @(negedge clk);
                adc0_miso = word_bit(w0, t);
                adc1_miso = word_bit(w1, t);
                if (t == 0)   dac_in = ~dac_nxt;            // R7 decoy after capture
                if (t == 150) dac_in = 12'($urandom);       // R7 decoy mid-frame
                if (t == 287) dac_in = dac_nxt;             // R7 value to capture
                chk("R2 cs_n", dac_cs_n, (t == 0));
                chk("R1 cs_n adc0", adc0_cs_n, dac_cs_n);
                chk("R1 cs_n adc1", adc1_cs_n, dac_cs_n);
                chk("R3 sclk", dac_sclk, exp_sclk(t));
                chk("R1 sclk adc0", adc0_sclk, dac_sclk);
                chk("R1 sclk adc1", adc1_sclk, dac_sclk);
                chk("R6 R7 mosi", dac_mosi, word_bit({4'b0000, dac_cur}, t));
                chk("R4 valid", adc_valid, (t == 284));
                if (t == 100) begin
                    chk("R4 hold data0", adc0_data, prev0);
                    chk("R4 hold data1", adc1_data, prev1);
                end
                if (t == 284) begin
                    chk("R5 data0", adc0_data, w0[11:0]);
                    chk("R5 data1", adc1_data, w1[11:0]);
                end
            end
            prev0 = w0[11:0];
            prev1 = w1[11:0];
            dac_cur = dac_nxt;
        end
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule